// File: doc/BRIEF.md
# Gated clock frequency counter

This block measures the rate of one internal clock. A select field picks that clock from up to 128 candidates. The block counts the rising edges of the selected clock over a gate window whose length is set in microseconds. Timing comes from a free-running system clock and a one-cycle microsecond tick, so the count divided by the window length gives the frequency in edges per microsecond. The selected clock goes through a two-flop synchronizer into the system domain before its edges are detected. Only clocks slower than half the system clock are counted correctly.

Software drives the block through a small 32-bit register interface with a 4-byte stride. A control word holds the window length, the source select and four mode bits, and it reports a busy flag. A result word holds the saturating edge count. A window starts when software sets run and enable together. Software then polls busy until it clears, or waits for the interrupt pulse, and reads the count. In continuous mode the block starts each new window on its own and refreshes the result at the end of every window.

Top module: `clk_rate_meter`

## Requirements
- R1: The control word is at byte offset 0x4. Bits 15:0 hold the window length minus one, in microseconds. Bit 16 is enable, bit 17 is continuous mode, bit 18 is interrupt enable, bit 19 is run, and bits 26:20 select the source. Each field reads back as written, as long as no window starts. Bits 30:27 read zero.
- R2: The result word is at byte offset 0xC and carries the count zero-extended in its low bits. Offsets 0x0 and 0x8 always read zero. After reset every register reads zero and the interrupt output is low.
- R3: A window starts on the clock edge that takes a control write when that write leaves both run and enable at 1 and no window is active. Busy (bit 31) reads 1 from the next cycle on, and run reads 0 from then on. A single-mode window does not restart by itself.
- R4: A window lasts exactly length+1 microsecond ticks after its start edge. If the start edge falls on a tick, busy stays set for (length+1) × tick-period system cycles.
- R5: The stored count equals the number of rising edges of the selected clock during the window, within ±1 edge.
- R6: A select value that points at a stopped clock gives a count of exactly zero, and so does a select value at or above the number of sources. Clocks that are not selected have no effect on the count.
- R7: The count saturates at all ones (0xFFFF at the default width). The all-ones value marks an overflow.
- R8: A control write that clears enable aborts an active window. Busy reads 0 in the next cycle, no interrupt fires, and the result word keeps its old value.
- R9: In continuous mode, busy stays set from one window to the next, each window has the programmed length, and the result updates at the end of every window.
- R10: When interrupt enable is set, the interrupt output pulses high for one cycle after each window ends, in the same cycle the new result becomes readable. When interrupt enable is clear, the output stays low.
- R11: The count restarts from zero in every window. A repeated measurement does not accumulate edges from earlier windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| us_tick | input | 1 | One-cycle pulse each microsecond |
| meas_clks | input | NUM_SRC | Candidate clocks to measure |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| irq | output | 1 | End-of-window pulse |

## Verification
The bench builds the block with NUM_SRC = 8 and CNT_W = 8, and it pulses the microsecond tick every 10 system cycles. The 8-bit counter saturates after 255 edges, so a 121-microsecond window on the fastest source reaches overflow in about 1200 cycles. With eight sources, one of them held stopped, the bench can sweep every select value against several window lengths. A select value above the source count then checks the out-of-range path. The bench aligns each start with a tick, so window lengths in cycles are exact and edge counts have a known ±1 bound.

// File: rtl/gcm_pkg.sv
package gcm_pkg;
  localparam int ADDR_W  = 4;
  localparam int DUR_W   = 16;
  localparam int SEL_FW  = 7;
  localparam int MAX_SRC = 1 << SEL_FW;
  localparam logic [ADDR_W-1:0] CTRL_OFS = 4'h4;
  localparam logic [ADDR_W-1:0] RES_OFS  = 4'hC;

  // packed so that sel lands on bits 26:20, run 19, ien 18, cont 17, en 16
  typedef struct packed {
    logic [SEL_FW-1:0] sel;
    logic              run;
    logic              ien;
    logic              cont;
    logic              en;
    logic [DUR_W-1:0]  dur;
  } ctrl_t;

  function automatic logic [31:0] ctrl_word(input ctrl_t c, input logic busy);
    return {busy, 4'b0000, c};
  endfunction

  function automatic ctrl_t ctrl_from_word(input logic [31:0] w);
    return ctrl_t'(w[26:0]);
  endfunction
endpackage

// File: rtl/gcm_src_sync.sv
module gcm_src_sync
  import gcm_pkg::*;
#(
  parameter int NUM_SRC = 128
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_SRC-1:0]  src,
  input  logic [SEL_FW-1:0]   sel,
  output logic                rise_o
);
  logic [MAX_SRC-1:0] padded;
  logic mux_o, s1, s2, s3;

  always_comb begin
    padded = '0;
    padded[NUM_SRC-1:0] = src;
  end
  assign mux_o = padded[sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= mux_o;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign rise_o = s2 & ~s3;
endmodule

// File: rtl/gcm_gate_timer.sv
module gcm_gate_timer #(
  parameter int DUR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic             cont,
  input  logic [DUR_W-1:0] dur,
  input  logic             tick,
  output logic             busy_o,
  output logic             end_o
);
  logic [DUR_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      remain <= '0;
    end else if (abort) begin
      busy_o <= 1'b0;
    end else if (start) begin
      busy_o <= 1'b1;
      remain <= dur;
    end else if (busy_o && tick) begin
      if (remain == '0) begin
        remain <= dur;
        busy_o <= cont;
      end else begin
        remain <= remain - 1'b1;
      end
    end
  end

  assign end_o = busy_o & tick & (remain == '0) & ~abort;

  AST_REMAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) && !$past(tick) && !$past(start) && !$past(abort))
      |-> $stable(remain)); // R4
endmodule

// File: rtl/gcm_sat_counter.sv
module gcm_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] cnt_inc_o
);
  function automatic logic [W-1:0] sat_add(input logic [W-1:0] v, input logic up);
    if (up && (v != '1)) return v + 1'b1;
    return v;
  endfunction

  assign cnt_inc_o = sat_add(cnt_o, inc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_o <= '0;
    else if (clr) cnt_o <= '0;
    else          cnt_o <= cnt_inc_o;
  end

  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt_o) == '1 && !$past(clr)) |-> (cnt_o == '1)); // R7
endmodule

// File: rtl/clk_rate_meter.sv
module clk_rate_meter
  import gcm_pkg::*;
#(
  parameter int NUM_SRC = 128,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               us_tick,
  input  logic [NUM_SRC-1:0] meas_clks,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               irq
);
  ctrl_t ctrl_q, wr_c;
  logic wr_ctrl, en_nxt, run_nxt, cont_nxt;
  logic [DUR_W-1:0] dur_nxt;
  logic start_evt, abort_evt, end_evt, busy, src_rise;
  logic [CNT_W-1:0] cnt, cnt_inc, result_q;
  logic unused_wbits;

  assign unused_wbits = ^reg_wdata[31:27];
  assign wr_c     = ctrl_from_word(reg_wdata);
  assign wr_ctrl  = reg_wr && (reg_addr == CTRL_OFS);
  assign en_nxt   = wr_ctrl ? wr_c.en   : ctrl_q.en;
  assign run_nxt  = wr_ctrl ? wr_c.run  : ctrl_q.run;
  assign cont_nxt = wr_ctrl ? wr_c.cont : ctrl_q.cont;
  assign dur_nxt  = wr_ctrl ? wr_c.dur  : ctrl_q.dur;

  assign start_evt = en_nxt & run_nxt & ~busy;
  assign abort_evt = ~en_nxt;

  gcm_src_sync #(.NUM_SRC(NUM_SRC)) u_sync (
    .clk(clk), .rst_n(rst_n), .src(meas_clks), .sel(ctrl_q.sel), .rise_o(src_rise)
  );

  gcm_gate_timer #(.DUR_W(DUR_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start_evt), .abort(abort_evt),
    .cont(cont_nxt), .dur(dur_nxt), .tick(us_tick), .busy_o(busy), .end_o(end_evt)
  );

  gcm_sat_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(start_evt | end_evt), .inc(src_rise & busy),
    .cnt_o(cnt), .cnt_inc_o(cnt_inc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      result_q <= '0;
      irq      <= 1'b0;
    end else begin
      if (wr_ctrl)   ctrl_q     <= wr_c;
      if (start_evt) ctrl_q.run <= 1'b0;
      if (end_evt)   result_q   <= cnt_inc;
      irq <= end_evt & ctrl_q.ien;
    end
  end

  always_comb begin
    case (reg_addr)
      CTRL_OFS: reg_rdata = ctrl_word(ctrl_q, busy);
      RES_OFS:  reg_rdata = 32'(result_q);
      default:  reg_rdata = '0;
    endcase
  end

  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.en |-> !busy); // R8
  AST_RUN_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !ctrl_q.run); // R3
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(end_evt) |-> $stable(result_q)); // R9
  AST_IRQ_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(busy)); // R10
endmodule

// File: tb/tb_clk_rate_meter.sv
module tb_clk_rate_meter;
  localparam int NSRC = 8;
  localparam int CW   = 8;
  localparam int TICK = 10;

  logic clk = 1'b0, rst_n = 1'b0, us_tick = 1'b0, reg_wr = 1'b0, irq;
  logic [NSRC-1:0] meas_clks = '0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  int total = 0, fails = 0, irq_n = 0, tcnt = 0;
  int hc [NSRC];
  bit done = 0;

  clk_rate_meter #(.NUM_SRC(NSRC), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .meas_clks(meas_clks),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  always #10 clk = ~clk;

  // tick generator and source clocks: source i has half period i+2 cycles, last one stopped
  always @(negedge clk) begin
    tcnt <= (tcnt == TICK-1) ? 0 : tcnt + 1;
    us_tick <= (tcnt == TICK-1);
    for (int i = 0; i < NSRC-1; i++) begin
      if (hc[i] >= i+1) begin hc[i] <= 0; meas_clks[i] <= ~meas_clks[i]; end
      else hc[i] <= hc[i] + 1;
    end
    if (irq) irq_n <= irq_n + 1;
  end

  function automatic logic [31:0] word(int sel, int run, int ien, int cont, int en, int dur);
    return (sel << 20) + (run << 19) + (ien << 18) + (cont << 17) + (en << 16) + (dur & 16'hFFFF);
  endfunction

  task automatic chk(input bit ok, input string req, input longint got, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); #2;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); #2;
    reg_wr = 1'b0;
  endtask

  task automatic aligned_write(input logic [31:0] d);
    do begin @(negedge clk); #2; end while (!us_tick);
    reg_wr = 1'b1; reg_addr = 4'h4; reg_wdata = d;
    @(negedge clk); #2;
    reg_wr = 1'b0;
  endtask

  function automatic bit near(int got, int w, int p);
    return (got * p >= w - p) && (got * p <= w + p);
  endfunction

  task automatic measure(input int sel, input int dur, input int ien, output int cnt, output int cyc);
    logic [31:0] v;
    int irq0;
    bus_write(4'h4, word(sel, 0, 0, 0, 0, dur));
    repeat (4) @(negedge clk);
    irq0 = irq_n;
    aligned_write(word(sel, 1, ien, 0, 1, dur));
    rd(4'h4, v);
    chk(v[31] == 1'b1, "R3 busy after start", v[31], 1);
    chk(v[19] == 1'b0, "R3 run cleared at start", v[19], 0);
    cyc = 0;
    while (v[31] && cyc < 100000) begin
      cyc++;
      @(negedge clk); #2;
      rd(4'h4, v);
    end
    chk(cyc == (dur + 1) * TICK, "R4 window length", cyc, (dur + 1) * TICK);
    repeat (3) @(negedge clk);
    chk(irq_n - irq0 == ien, "R10 irq pulses", irq_n - irq0, ien);
    rd(4'hC, v);
    cnt = int'(v);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL R4 watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v, res0;
    int cnt, cyc, w, p, irq0;
    for (int i = 0; i < NSRC; i++) hc[i] = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 reset state and unused offsets
    for (int a = 0; a < 16; a += 4) begin
      rd(4'(a), v);
      chk(v == 0, "R2 reset readback", v, 0);
    end
    chk(irq == 1'b0, "R2 irq low after reset", irq, 0);

    // R1 field readback without start (enable clear)
    bus_write(4'h4, word(7'h55, 1, 1, 1, 0, 16'h1234));
    rd(4'h4, v);
    chk(v == word(7'h55, 1, 1, 1, 0, 16'h1234), "R1 control readback", v, word(7'h55, 1, 1, 1, 0, 16'h1234));
    bus_write(4'h4, 32'hFFFF_FFFF & ~(32'h1 << 16) & ~(32'h1 << 19));
    rd(4'h4, v);
    chk(v[30:27] == 0 && v[31] == 0, "R1 reserved and busy bits", v[31:27], 0);
    bus_write(4'h4, 0);

    // R5 sweep over sources and window lengths
    for (int s = 0; s < NSRC-1; s++) begin
      foreach (p_durs[k]) begin
        measure(s, p_durs[k], 1, cnt, cyc);
        w = (p_durs[k] + 1) * TICK; p = 2 * (s + 2);
        chk(near(cnt, w, p), "R5 edge count", cnt, w / p);
      end
    end

    // R6 stopped source and out-of-range select read exactly zero
    measure(NSRC-1, 7, 1, cnt, cyc);
    chk(cnt == 0, "R6 stopped source", cnt, 0);
    measure(100, 7, 1, cnt, cyc);
    chk(cnt == 0, "R6 select out of range", cnt, 0);

    // R11 repeated window restarts from zero
    measure(1, 3, 1, cnt, cyc);
    measure(1, 3, 1, cnt, cyc);
    chk(near(cnt, 40, 6), "R11 second window not accumulated", cnt, 40 / 6);

    // R7 saturation on fast source, no saturation on slow source
    measure(0, 120, 1, cnt, cyc);
    chk(cnt == (1 << CW) - 1, "R7 saturated count", cnt, (1 << CW) - 1);
    measure(6, 120, 1, cnt, cyc);
    chk(near(cnt, 1210, 16), "R7 long window below limit", cnt, 1210 / 16);

    // R10 no interrupt with interrupt enable clear
    measure(2, 2, 0, cnt, cyc);
    chk(near(cnt, 30, 8), "R10 count with irq disabled", cnt, 30 / 8);

    // R3 single mode does not restart
    irq0 = irq_n;
    repeat (100) @(negedge clk);
    rd(4'h4, v);
    chk(v[31] == 0, "R3 no restart in single mode", v[31], 0);
    chk(irq_n == irq0, "R3 no further irq", irq_n - irq0, 0);

    // R8 abort
    rd(4'hC, res0);
    irq0 = irq_n;
    aligned_write(word(0, 1, 1, 0, 1, 500));
    repeat (50) @(negedge clk);
    bus_write(4'h4, word(0, 0, 1, 0, 0, 500));
    rd(4'h4, v);
    chk(v[31] == 0, "R8 busy cleared by abort", v[31], 0);
    repeat (6000) @(negedge clk);
    chk(irq_n == irq0, "R8 no irq after abort", irq_n - irq0, 0);
    rd(4'hC, v);
    chk(v == res0, "R8 result kept", v, res0);

    // R9 continuous mode
    bus_write(4'h4, word(3, 0, 1, 1, 0, 4));
    repeat (4) @(negedge clk);
    irq0 = irq_n;
    aligned_write(word(3, 1, 1, 1, 1, 4));
    repeat (8 * 50 + 2) @(negedge clk);
    #2;
    chk(irq_n - irq0 == 8, "R9 one irq per window", irq_n - irq0, 8);
    rd(4'h4, v);
    chk(v[31] == 1, "R9 busy held between windows", v[31], 1);
    rd(4'hC, v);
    chk(near(int'(v), 50, 10), "R9 result refreshed", v, 5);
    bus_write(4'h4, 0);
    rd(4'h4, v);
    chk(v[31] == 0, "R8 continuous abort", v[31], 0);

    done = 1;
    summary();
    $finish;
  end

  int p_durs [3] = '{0, 2, 7};
endmodule